// File: doc/BRIEF.md
# Tile Matrix Multiply Sequencer

This block holds three small register tiles: two byte operands, A and B, and a destination of 32-bit accumulators. On command it computes dst += A × B over them. A is an M-row tile whose rows hold K bytes. B holds K/4 rows of N 32-bit words, and each word packs the four bytes that meet one group of four A bytes. The destination is an M × N grid of 32-bit words.

The sequencer walks output rows, then output columns, then groups of four bytes along K. Each step feeds one byte-wise dot product into a running sum. The sum is written back to the destination when the last group of an element is done. A second command clears the destination within an M × N shape. The tiles are filled and drained through a plain word write port and a word read port. A neighbouring load/store unit would use those ports.

Top module: `tile_mm_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low, and every destination word reads as zero.
- R2: When the block is idle, ld_we_i writes ld_data_i into word ld_word_i of row ld_row_i of the tile that ld_tile_i selects (0 = A, 1 = B, 2 = destination). Select value 3 writes nothing. rd_data_o shows destination word (rd_row_i, rd_word_i) combinationally.
- R3: A multiply command updates each dst[m][n] with m < M and n < N by adding the sum, over k < K, of a(m,k) × b(k,n), wrapping modulo 2^32. a(m,k) is byte k%4 (bits 8i+7:8i, with i = k%4) of A row m, word k/4. b(k,n) is byte k%4 of B row k/4, word n.
- R4: mode_i[1] set makes the A bytes two's-complement signed, and clear makes them unsigned. mode_i[0] does the same for the B bytes.
- R5: A valid multiply keeps busy_o high for exactly M·N·(K/4) cycles, starting in the cycle after start_i is sampled. done_o is high for one cycle, in the first cycle with busy_o low, and err_o stays low.
- R6: A multiply is rejected if M or N is 0 or above 16, or K is 0, above 64 or not a multiple of 4. A clear is rejected if M or N is out of range. A rejected command never raises busy_o. done_o and err_o pulse together in the next cycle, and the destination is left unchanged.
- R7: While busy_o is high, start_i and zero_i are ignored, and changes on the shape and mode inputs have no effect, because these are captured when a command is accepted.
- R8: A clear command zeroes dst[m][n] for m < M and n < N, with busy_o high for M·N cycles.
- R9: Destination words outside the M × N shape are not changed by a multiply or a clear.
- R10: Tile writes on the load port are dropped while busy_o is high.
- R11: If start_i and zero_i are sampled high in the same idle cycle, the multiply is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_we_i | input | 1 | Tile word write enable |
| ld_tile_i | input | 2 | Tile select: 0 A, 1 B, 2 destination, 3 none |
| ld_row_i | input | 4 | Row of the written word |
| ld_word_i | input | 4 | Word index within the row |
| ld_data_i | input | 32 | Write data |
| rd_row_i | input | 4 | Destination read row |
| rd_word_i | input | 4 | Destination read word |
| rd_data_o | output | 32 | Destination read data |
| start_i | input | 1 | Multiply command strobe |
| zero_i | input | 1 | Clear command strobe |
| mode_i | input | 2 | Signedness of A (bit 1) and B (bit 0) |
| m_rows_i | input | 5 | M: rows of A and of the result |
| k_bytes_i | input | 7 | K: bytes per A row |
| n_cols_i | input | 5 | N: 32-bit columns of B and of the result |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected command, pulses with done_o |

## Verification
The assertions check the handshake on every cycle. Busy can only fall together with done. Done never overlaps busy. An error is always paired with done and only follows an idle cycle. Busy only rises after a command strobe. The arithmetic across sign modes, the step counts for each shape, the shape checks and the untouched words outside the shape are shown only by the bench scenarios. Those scenarios compare the whole destination tile with a bench model after each command. The same holds for the commands and tile writes that are dropped while busy.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * 8;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_D = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_CLR  = 2'd2
  } tmm_state_e;
endpackage

// File: rtl/tmm_dot4.sv
module tmm_dot4 import tmm_pkg::*; (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  output logic [WORD_W-1:0] dot_o
);
  logic signed [17:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [8:0] a_x, b_x;
    assign a_x     = {a_signed_i & a_i[8*g+7], a_i[8*g +: 8]};
    assign b_x     = {b_signed_i & b_i[8*g+7], b_i[8*g +: 8]};
    assign prod[g] = a_x * b_x;
  end

  always_comb begin
    dot_o = '0;
    for (int i = 0; i < LANES; i++) dot_o = dot_o + WORD_W'(prod[i]);
  end
endmodule

// File: rtl/tmm_tile_rf.sv
module tmm_tile_rf import tmm_pkg::*; #(
  parameter int ROWS  = 16,
  parameter int WORDS = 16,
  parameter int N_RD  = 1,
  parameter int AW    = $clog2(ROWS * WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic [N_RD*AW-1:0]       raddr_i,
  output logic [N_RD*WORD_W-1:0]   rdata_o
);
  localparam int DEPTH = ROWS * WORDS;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g*WORD_W +: WORD_W] = mem[raddr_i[g*AW +: AW]];
  end
endmodule

// File: rtl/tmm_seq.sv
module tmm_seq import tmm_pkg::*; #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int WORDS     = ROW_BYTES / LANES,
  parameter int RW        = $clog2(ROWS),
  parameter int WW        = $clog2(WORDS),
  parameter int M_W       = $clog2(ROWS + 1),
  parameter int N_W       = $clog2(WORDS + 1),
  parameter int K_W       = $clog2(ROW_BYTES + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           zero_i,
  input  logic [1:0]     mode_i,
  input  logic [M_W-1:0] m_rows_i,
  input  logic [K_W-1:0] k_bytes_i,
  input  logic [N_W-1:0] n_cols_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [RW-1:0]  row_o,
  output logic [WW-1:0]  col_o,
  output logic [WW-1:0]  grp_o,
  output logic           first_o,
  output logic           last_o,
  output logic           mac_o,
  output logic           clr_o,
  output logic           a_signed_o,
  output logic           b_signed_o
);
  tmm_state_e     state_q;
  logic [RW-1:0]  row_q, row_last_q;
  logic [WW-1:0]  col_q, col_last_q;
  logic [WW-1:0]  grp_q, grp_last_q;
  logic [1:0]     mode_q;
  logic           done_q, err_q;
  logic           m_ok, n_ok, k_ok;
  logic [K_W-3:0] k_grp;

  assign k_grp = k_bytes_i[K_W-1:2];
  assign m_ok  = (m_rows_i != '0) && (m_rows_i <= M_W'(ROWS));
  assign n_ok  = (n_cols_i != '0) && (n_cols_i <= N_W'(WORDS));
  assign k_ok  = (k_bytes_i != '0) && (k_bytes_i <= K_W'(ROW_BYTES)) &&
                 (k_bytes_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      grp_q      <= '0;
      row_last_q <= '0;
      col_last_q <= '0;
      grp_last_q <= '0;
      mode_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i || zero_i) begin
            // start has priority over zero
            if (start_i ? (m_ok && n_ok && k_ok) : (m_ok && n_ok)) begin
              state_q    <= start_i ? ST_MAC : ST_CLR;
              row_q      <= '0;
              col_q      <= '0;
              grp_q      <= '0;
              row_last_q <= RW'(m_rows_i - M_W'(1));
              col_last_q <= WW'(n_cols_i - N_W'(1));
              grp_last_q <= start_i ? WW'(k_grp - (K_W-2)'(1)) : '0;
              mode_q     <= mode_i;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        ST_MAC, ST_CLR: begin
          if (grp_q == grp_last_q) begin
            grp_q <= '0;
            if (col_q == col_last_q) begin
              col_q <= '0;
              if (row_q == row_last_q) begin
                row_q   <= '0;
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                row_q <= row_q + RW'(1);
              end
            end else begin
              col_q <= col_q + WW'(1);
            end
          end else begin
            grp_q <= grp_q + WW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign grp_o      = grp_q;
  assign first_o    = (grp_q == '0);
  assign last_o     = (grp_q == grp_last_q);
  assign mac_o      = (state_q == ST_MAC);
  assign clr_o      = (state_q == ST_CLR);
  assign a_signed_o = mode_q[1];
  assign b_signed_o = mode_q[0];
endmodule

// File: rtl/tile_mm_seq.sv
module tile_mm_seq import tmm_pkg::*; #(
  parameter  int ROWS      = 16,
  parameter  int ROW_BYTES = 64,
  localparam int WORDS     = ROW_BYTES / LANES,
  localparam int RW        = $clog2(ROWS),
  localparam int WW        = $clog2(WORDS),
  localparam int M_W       = $clog2(ROWS + 1),
  localparam int N_W       = $clog2(WORDS + 1),
  localparam int K_W       = $clog2(ROW_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [1:0]        ld_tile_i,
  input  logic [RW-1:0]     ld_row_i,
  input  logic [WW-1:0]     ld_word_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic [RW-1:0]     rd_row_i,
  input  logic [WW-1:0]     rd_word_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              start_i,
  input  logic              zero_i,
  input  logic [1:0]        mode_i,
  input  logic [M_W-1:0]    m_rows_i,
  input  logic [K_W-1:0]    k_bytes_i,
  input  logic [N_W-1:0]    n_cols_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int AW = RW + WW;

  logic              busy, mac, clr, first, last, a_sgn, b_sgn;
  logic [RW-1:0]     row;
  logic [WW-1:0]     col, grp;
  logic [WORD_W-1:0] a_word, b_word, d_cur, dot, sum, acc_q;
  logic [2*WORD_W-1:0] d_rd;
  logic              ext_wr, seq_wr, d_we;
  logic [AW-1:0]     d_waddr;
  logic [WORD_W-1:0] d_wdata;

  tmm_seq #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .WORDS(WORDS), .RW(RW), .WW(WW),
    .M_W(M_W), .N_W(N_W), .K_W(K_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .zero_i, .mode_i, .m_rows_i, .k_bytes_i, .n_cols_i,
    .busy_o(busy), .done_o, .err_o,
    .row_o(row), .col_o(col), .grp_o(grp), .first_o(first), .last_o(last),
    .mac_o(mac), .clr_o(clr), .a_signed_o(a_sgn), .b_signed_o(b_sgn)
  );

  assign ext_wr = ld_we_i && !busy;

  tmm_tile_rf #(.ROWS(ROWS), .WORDS(WORDS), .N_RD(1), .AW(AW)) u_tile_a (
    .clk_i, .rst_ni,
    .we_i(ext_wr && (ld_tile_i == SEL_A)),
    .waddr_i({ld_row_i, ld_word_i}),
    .wdata_i(ld_data_i),
    .raddr_i({row, grp}),
    .rdata_o(a_word)
  );

  // B row index is the K group
  tmm_tile_rf #(.ROWS(ROWS), .WORDS(WORDS), .N_RD(1), .AW(AW)) u_tile_b (
    .clk_i, .rst_ni,
    .we_i(ext_wr && (ld_tile_i == SEL_B)),
    .waddr_i({ld_row_i, ld_word_i}),
    .wdata_i(ld_data_i),
    .raddr_i({RW'(grp), col}),
    .rdata_o(b_word)
  );

  assign seq_wr  = (mac && last) || clr;
  assign d_we    = seq_wr || (ext_wr && (ld_tile_i == SEL_D));
  assign d_waddr = seq_wr ? {row, col} : {ld_row_i, ld_word_i};
  assign d_wdata = clr ? '0 : (seq_wr ? sum : ld_data_i);

  tmm_tile_rf #(.ROWS(ROWS), .WORDS(WORDS), .N_RD(2), .AW(AW)) u_tile_d (
    .clk_i, .rst_ni,
    .we_i(d_we),
    .waddr_i(d_waddr),
    .wdata_i(d_wdata),
    .raddr_i({rd_row_i, rd_word_i, row, col}),
    .rdata_o(d_rd)
  );

  assign d_cur     = d_rd[WORD_W-1:0];
  assign rd_data_o = d_rd[2*WORD_W-1:WORD_W];

  tmm_dot4 u_dot (
    .a_i(a_word), .b_i(b_word), .a_signed_i(a_sgn), .b_signed_i(b_sgn), .dot_o(dot)
  );

  // first group seeds from the stored accumulator
  assign sum = (first ? d_cur : acc_q) + dot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= '0;
    else if (mac && !last)   acc_q <= sum;
  end

  assign busy_o = busy;
endmodule

// File: rtl/tmm_sva.sv
module tmm_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic zero_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  // R5: busy only ends with a done pulse
  a_r5_fall_has_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5: done is never raised while still busy
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6: error always travels with done
  a_r6_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R6 R7: a rejection only follows an idle cycle
  a_r6_err_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(busy_o));

  // R7: busy only rises after a command strobe
  a_r7_busy_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i || zero_i));
endmodule

bind tile_mm_seq tmm_sva u_tmm_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .zero_i(zero_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tile_mm_seq_test.sv
module tile_mm_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;
  localparam int NW = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_tile = '0;
  logic [3:0]  ld_row = '0, ld_word = '0, rd_row = '0, rd_word = '0;
  logic [31:0] ld_data = '0, rd_data;
  logic        start = 1'b0, zero = 1'b0;
  logic [1:0]  mode = '0;
  logic [4:0]  m_rows = '0, n_cols = '0;
  logic [6:0]  k_bytes = '0;
  logic        busy, done, err;

  logic [31:0] ma [NR][NW];
  logic [31:0] mb [NR][NW];
  logic [31:0] md [NR][NW];
  logic [31:0] seed = 32'h1234_5678;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tile_mm_seq uut (
    .clk_i, .rst_ni,
    .ld_we_i(ld_we), .ld_tile_i(ld_tile), .ld_row_i(ld_row), .ld_word_i(ld_word),
    .ld_data_i(ld_data), .rd_row_i(rd_row), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .start_i(start), .zero_i(zero), .mode_i(mode),
    .m_rows_i(m_rows), .k_bytes_i(k_bytes), .n_cols_i(n_cols),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic wr(input logic [1:0] t, input int r, input int w, input logic [31:0] d);
    ld_we = 1'b1; ld_tile = t; ld_row = 4'(r); ld_word = 4'(w); ld_data = d;
    step();
    ld_we = 1'b0;
  endtask

  task automatic check_dst(input string req);
    int bad = 0;
    logic [31:0] got = '0, exp = '0;
    for (int r = 0; r < NR; r++) begin
      for (int w = 0; w < NW; w++) begin
        rd_row = 4'(r); rd_word = 4'(w);
        #1;
        if (rd_data !== md[r][w]) begin
          if (bad == 0) begin got = rd_data; exp = md[r][w]; end
          bad++;
        end
      end
    end
    chk(bad == 0, req, "destination tile", longint'(got), longint'(exp));
  endtask

  function automatic bit shape_ok(int m, int k, int n, bit need_k);
    bit ok = (m >= 1) && (m <= NR) && (n >= 1) && (n <= NW);
    if (need_k) ok = ok && (k >= 1) && (k <= 4*NW) && (k % 4 == 0);
    return ok;
  endfunction

  task automatic model_mac(input int m, input int k, input int n, input logic [1:0] md_sel);
    for (int r = 0; r < m; r++) begin
      for (int c = 0; c < n; c++) begin
        logic [31:0] acc = md[r][c];
        for (int kk = 0; kk < k; kk++) begin
          int av = int'((ma[r][kk/4] >> (8*(kk%4))) & 32'hff);
          int bv = int'((mb[kk/4][c] >> (8*(kk%4))) & 32'hff);
          if (md_sel[1] && av > 127) av -= 256;
          if (md_sel[0] && bv > 127) bv -= 256;
          acc = acc + 32'(av * bv);
        end
        md[r][c] = acc;
      end
    end
  endtask

  task automatic run_op(input bit do_mac, input bit do_zero, input int m, input int k,
                        input int n, input logic [1:0] md_sel, input string req);
    bit valid = shape_ok(m, k, n, do_mac);
    int exp_cyc = valid ? (do_mac ? m*n*(k/4) : m*n) : 0;
    int cnt = 0;
    start = do_mac; zero = do_zero; mode = md_sel;
    m_rows = 5'(m); k_bytes = 7'(k); n_cols = 5'(n);
    step();
    start = 1'b0; zero = 1'b0;
    while (busy && cnt < 70000) begin cnt++; step(); end
    chk(cnt == exp_cyc, req, "busy cycles", cnt, exp_cyc);
    chk(done == 1'b1, "R5", "done at end", done, 1);
    chk(err == !valid, "R6", "err flag", err, !valid);
    step();
    chk(done == 1'b0, "R5", "done single pulse", done, 0);
    if (valid) begin
      if (do_mac) model_mac(m, k, n, md_sel);
      else for (int r = 0; r < m; r++) for (int c = 0; c < n; c++) md[r][c] = '0;
    end
    check_dst({req, " R9"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int ms[3] = '{1, 3, 16};
    int ns[3] = '{1, 2, 16};
    int ks[3] = '{4, 12, 64};
    int cnt;
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < NW; w++) begin ma[r][w] = '0; mb[r][w] = '0; md[r][w] = '0; end

    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(err == 1'b0, "R1", "err", err, 0);
    rst_ni = 1'b1;
    step();
    check_dst("R1");

    // R2: load tiles
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < NW; w++) begin
        ma[r][w] = next_rand(); wr(2'd0, r, w, ma[r][w]);
        mb[r][w] = next_rand(); wr(2'd1, r, w, mb[r][w]);
        md[r][w] = next_rand(); wr(2'd2, r, w, md[r][w]);
      end
    check_dst("R2");
    wr(2'd3, 0, 0, 32'h1234_5678);
    check_dst("R2 select 3");

    // R3 R4 R5: shape and sign-mode sweep
    for (int md_i = 0; md_i < 4; md_i++)
      foreach (ms[i]) foreach (ns[j]) foreach (ks[q])
        run_op(1'b1, 1'b0, ms[i], ks[q], ns[j], 2'(md_i), "R3 R4 R5");

    // R6: rejected shapes
    run_op(1'b1, 1'b0, 2, 6, 2, 2'd3, "R6 k not x4");
    run_op(1'b1, 1'b0, 0, 4, 2, 2'd0, "R6 m zero");
    run_op(1'b1, 1'b0, 2, 4, 0, 2'd0, "R6 n zero");
    run_op(1'b1, 1'b0, 17, 4, 2, 2'd0, "R6 m big");
    run_op(1'b1, 1'b0, 2, 68, 2, 2'd0, "R6 k big");
    run_op(1'b1, 1'b0, 2, 4, 17, 2'd0, "R6 n big");
    run_op(1'b1, 1'b0, 2, 0, 2, 2'd0, "R6 k zero");
    run_op(1'b0, 1'b1, 3, 0, 0, 2'd0, "R6 clear n zero");

    // R8: clear within shape
    run_op(1'b0, 1'b1, 3, 0, 5, 2'd0, "R8");

    // R11: start and zero together
    run_op(1'b1, 1'b1, 2, 4, 2, 2'd1, "R11");

    // R7 R10: disturbances while busy
    start = 1'b1; mode = 2'd3; m_rows = 5'd2; k_bytes = 7'd8; n_cols = 5'd3;
    step();
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 70000) begin
      cnt++;
      if (cnt == 2) begin
        start = 1'b1; zero = 1'b1; mode = 2'd0;
        m_rows = 5'd16; k_bytes = 7'd64; n_cols = 5'd16;
        ld_we = 1'b1; ld_tile = 2'd0; ld_row = 4'd0; ld_word = 4'd0; ld_data = 32'h7f7f_7f7f;
      end else if (cnt == 3) begin
        start = 1'b0; zero = 1'b0;
        ld_tile = 2'd2; ld_row = 4'd15; ld_word = 4'd15; ld_data = 32'h0000_dead;
      end else begin
        ld_we = 1'b0;
      end
      step();
    end
    ld_we = 1'b0;
    chk(cnt == 12, "R7", "busy cycles", cnt, 12);
    chk(done == 1'b1, "R7", "done", done, 1);
    step();
    chk(busy == 1'b0, "R7", "no restart", busy, 0);
    model_mac(2, 8, 3, 2'd3);
    check_dst("R7 R10");
    run_op(1'b1, 1'b0, 1, 4, 1, 2'd0, "R10 A intact");

    // R8 R9: full clear then accumulate from zero
    run_op(1'b0, 1'b1, 16, 0, 16, 2'd0, "R8 full");
    run_op(1'b1, 1'b0, 16, 64, 16, 2'd2, "R3 after clear");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule